// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block drives the four gates of one H-bridge winding and keeps the winding current near a set level by chopping. A phase sequencer chooses the polarity. The block then switches on the diagonal pair of transistors that drives current in that direction. It keeps that pair on until a digitised sense flag reports that the current has passed the reference. At that point the bridge is held in a recirculation pattern for a fixed number of clock cycles, and then it turns back on.

Right after the on pattern is applied, the sense flag is not trusted for a programmable number of cycles, so that switching spikes cannot end the on-time early. Every change from one non-zero gate pattern to another passes through an all-off gap of fixed length. This guarantees that no leg ever has both of its transistors on. A select input sets the recirculation style:
- Shorting the winding through both upper switches gives a gentle current decline.
- Reversing the voltage across the winding gives a fast decline.

The enable input and an "off" command from the sequencer shut the bridge down. A status output shows the current phase of the cycle.

Top module: `cot_chopper`

## Requirements
- R1: After reset the status reads IDLE (0) and all four gate outputs are low; in IDLE all gates stay low.
- R2: With phase_cmd 2'b01 the on pattern is hs_a and ls_b high; with 2'b10 it is hs_b and ls_a high. This pattern is driven in status BLANK (2) and ON (3).
- R3: Entering the on pattern, from IDLE or after an off-time, the status first reads DEAD (1) with all gates low for exactly DEAD_CYC cycles. A trip enters the same gap before the off-time.
- R4: After the dead gap, status BLANK lasts blank_cycles cycles, and trip has no effect during it. Status ON follows.
- R5: A high trip sampled at a clock edge while status is ON moves the block to DEAD and then to OFF (4). OFF lasts off_cycles cycles.
- R6: If slow_decay is high when OFF begins, the off pattern is hs_a and hs_b high with both low sides off.
- R7: If slow_decay is low when OFF begins, the off pattern is the opposite diagonal of the on pattern. The decay choice is held for the whole off-time.
- R8: When the off-time ends, the block passes through DEAD and BLANK and returns to ON with the same polarity.
- R9: A change of phase_cmd between 2'b01 and 2'b10 in any active status aborts it. The block enters DEAD and then runs an on-time with the new polarity.
- R10: enable low forces all gates low in the same cycle. Either enable low or phase_cmd 2'b00/2'b11 sends the status to IDLE at the next edge.
- R11: hs_a and ls_a are never high together, and neither are hs_b and ls_b. Between two different non-zero patterns there is always at least one all-low cycle.
- R12: An off_cycles or blank_cycles value of 0 acts as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Bridge enable; low turns every switch off |
| phase_cmd | input | 2 | Polarity from sequencer: 01 forward, 10 reverse, 00/11 off |
| slow_decay | input | 1 | Recirculation select: 1 slow, 0 fast |
| trip | input | 1 | Synchronous sense-comparator flag, high when current exceeds reference |
| off_cycles | input | OFF_W | Off-time length in clock cycles |
| blank_cycles | input | BLK_W | Blanking length in clock cycles |
| hs_a | output | 1 | Leg A high-side gate |
| ls_a | output | 1 | Leg A low-side gate |
| hs_b | output | 1 | Leg B high-side gate |
| ls_b | output | 1 | Leg B low-side gate |
| state | output | 3 | Status: 0 IDLE, 1 DEAD, 2 BLANK, 3 ON, 4 OFF |

## Verification
Random trip pulses arriving in every status separate a design that obeys blanking from one that cuts the on-time short. They also show that trips during the off-time and dead gap are ignored. Random off and blank lengths include zero and short values to expose off-by-one counting. Alternating slow_decay values, latched at different points, tell the two recirculation patterns apart. Rare polarity flips, off commands and enable drops land mid-cycle, which shows that aborts always return through the dead gap or to IDLE.

// File: rtl/cot_chopper.sv
module cot_chopper #(
  parameter int OFF_W    = 12,
  parameter int BLK_W    = 8,
  parameter int DEAD_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       phase_cmd,
  input  logic             slow_decay,
  input  logic             trip,
  input  logic [OFF_W-1:0] off_cycles,
  input  logic [BLK_W-1:0] blank_cycles,
  output logic             hs_a,
  output logic             ls_a,
  output logic             hs_b,
  output logic             ls_b,
  output logic [2:0]       state
);

  localparam int DW  = $clog2(DEAD_CYC + 1);
  localparam int CW0 = (OFF_W > BLK_W) ? OFF_W : BLK_W;
  localparam int CW  = (CW0 > DW) ? CW0 : DW;
  localparam logic [CW-1:0] ONE     = CW'(1);
  localparam logic [CW-1:0] DEAD_LD = CW'(DEAD_CYC - 1);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_DEAD  = 3'd1;
  localparam logic [2:0] S_BLANK = 3'd2;
  localparam logic [2:0] S_ON    = 3'd3;
  localparam logic [2:0] S_OFF   = 3'd4;

  logic [CW-1:0] cnt;
  logic [1:0]    pol;
  logic          to_off;
  logic          slow_q;

  wire cmd_ok   = (phase_cmd == 2'b01) || (phase_cmd == 2'b10);
  wire cnt_done = (cnt == '0);
  wire [CW-1:0] off_ld = (off_cycles == '0)   ? '0 : CW'(off_cycles) - ONE;
  wire [CW-1:0] blk_ld = (blank_cycles == '0) ? '0 : CW'(blank_cycles) - ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      pol    <= 2'b01;
      to_off <= 1'b0;
      slow_q <= 1'b0;
    end else if (!enable || !cmd_ok) begin
      state <= S_IDLE;
    end else if (state == S_IDLE || phase_cmd != pol) begin
      state  <= S_DEAD;
      pol    <= phase_cmd;
      to_off <= 1'b0;
      cnt    <= DEAD_LD;
    end else begin
      case (state)
        S_DEAD:
          if (cnt_done) begin
            if (to_off) begin
              state  <= S_OFF;
              cnt    <= off_ld;
              slow_q <= slow_decay;
            end else begin
              state <= S_BLANK;
              cnt   <= blk_ld;
            end
          end else cnt <= cnt - ONE;
        S_BLANK:
          if (cnt_done) state <= S_ON;
          else          cnt   <= cnt - ONE;
        S_ON:
          if (trip) begin
            state  <= S_DEAD;
            to_off <= 1'b1;
            cnt    <= DEAD_LD;
          end
        S_OFF:
          if (cnt_done) begin
            state  <= S_DEAD;
            to_off <= 1'b0;
            cnt    <= DEAD_LD;
          end else cnt <= cnt - ONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  wire       fwd     = (pol == 2'b01);
  wire [3:0] on_pat  = fwd ? 4'b1001 : 4'b0110;
  wire [3:0] off_pat = slow_q ? 4'b1010 : ~on_pat;
  wire [3:0] drive   = !enable                               ? 4'b0000 :
                       (state == S_ON || state == S_BLANK)   ? on_pat  :
                       (state == S_OFF)                      ? off_pat : 4'b0000;

  assign {hs_a, ls_a, hs_b, ls_b} = drive;

endmodule

// File: rtl/cot_chopper_chk.sv
module cot_chopper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [2:0] state,
  input logic [3:0] g
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0) |-> (g == 4'b0000)); // R1

  AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(g[3] && g[2])); // R11

  AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(g[1] && g[0])); // R11

  AST_NO_HARD_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (g != 4'b0000 && $past(g) != 4'b0000) |-> (g == $past(g))); // R11

  AST_BLANK_AFTER_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 && $past(state) != 3'd2) |-> ($past(state) == 3'd1)); // R3

  AST_OFF_AFTER_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && $past(state) != 3'd4) |-> ($past(state) == 3'd1)); // R5

  AST_DISABLED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (g == 4'b0000)); // R10

endmodule

bind cot_chopper cot_chopper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .state(state),
  .g({hs_a, ls_a, hs_b, ls_b})
);

// File: tb/sim_cot_chopper.sv
`timescale 1ns/1ps
module sim_cot_chopper;
  localparam int DEAD = 8;

  logic clk = 0, rst_n = 0, enable = 0, slow_decay = 0, trip = 0;
  logic [1:0]  phase_cmd = 2'b00;
  logic [11:0] off_cycles = 12'd5;
  logic [7:0]  blank_cycles = 8'd3;
  logic hs_a, ls_a, hs_b, ls_b;
  logic [2:0] state;

  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  cot_chopper #(.OFF_W(12), .BLK_W(8), .DEAD_CYC(DEAD)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .phase_cmd(phase_cmd),
    .slow_decay(slow_decay), .trip(trip), .off_cycles(off_cycles),
    .blank_cycles(blank_cycles), .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b),
    .ls_b(ls_b), .state(state));

  // reference model built from the requirements
  int m_st = 0, m_cnt = 0;
  logic [1:0] m_pol = 2'b01;
  logic m_off = 0, m_slow = 0;
  string m_ev = "none";

  function automatic int span(input int n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  function automatic logic [3:0] exp_gates(input int st, input logic [1:0] pol,
                                           input logic slow, input logic en);
    logic [3:0] onp;
    onp = (pol == 2'b01) ? 4'b1001 : 4'b0110;
    if (!en) return 4'b0000;
    if (st == 2 || st == 3) return onp;
    if (st == 4) return slow ? 4'b1010 : ~onp;
    return 4'b0000;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_pol = 2'b01; m_off = 0; m_slow = 0; m_ev = "R1";
    end else if (!enable || phase_cmd == 2'b00 || phase_cmd == 2'b11) begin
      m_st = 0; m_ev = "R10";
    end else if (m_st == 0 || phase_cmd != m_pol) begin
      m_ev = (m_st == 0) ? "R3" : "R9";
      m_st = 1; m_pol = phase_cmd; m_off = 0; m_cnt = DEAD - 1;
    end else begin
      case (m_st)
        1: if (m_cnt == 0) begin
             if (m_off) begin
               m_st = 4; m_cnt = span(int'(off_cycles)); m_slow = slow_decay;
               m_ev = (off_cycles == 0) ? "R12" : (slow_decay ? "R6" : "R7");
             end else begin
               m_st = 2; m_cnt = span(int'(blank_cycles));
               m_ev = (blank_cycles == 0) ? "R12" : "R4";
             end
           end else m_cnt--;
        2: if (m_cnt == 0) begin m_st = 3; m_ev = "R8"; end else m_cnt--;
        3: if (trip) begin m_st = 1; m_off = 1; m_cnt = DEAD - 1; m_ev = "R5"; end
        4: if (m_cnt == 0) begin m_st = 1; m_off = 0; m_cnt = DEAD - 1; m_ev = "R8"; end
           else m_cnt--;
        default: m_st = 0;
      endcase
    end
  end

  task automatic check_now();
    logic [3:0] g, e;
    string tag;
    g = {hs_a, ls_a, hs_b, ls_b};
    e = exp_gates(m_st, m_pol, m_slow, enable);
    case (m_st)
      0: tag = "R10"; 1: tag = "R3"; 2: tag = "R4"; 3: tag = "R2";
      default: tag = m_slow ? "R6" : "R7";
    endcase
    checks++;
    if (int'(state) != m_st || g != e) begin
      fails++;
      $display("FAIL %s (event %s) cycle %0d: state %0d gates %b, expected state %0d gates %b",
               tag, m_ev, cyc, state, g, m_st, e);
    end
    checks++;
    if ((hs_a && ls_a) || (hs_b && ls_b)) begin
      fails++;
      $display("FAIL R11 cycle %0d: gates %b, expected no leg shoot-through", cyc, g);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      check_now();
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_c0f1));
    // R1: reset state
    #20;
    checks++;
    if (state !== 3'd0 || {hs_a, ls_a, hs_b, ls_b} !== 4'b0000) begin
      fails++;
      $display("FAIL R1: state %0d gates %b, expected 0 0000", state, {hs_a, ls_a, hs_b, ls_b});
    end
    @(negedge clk); rst_n = 1;
    step(3);
    // directed: constant trip, blanking must hold it off (R4), slow then fast off (R6, R7)
    enable = 1; phase_cmd = 2'b01; trip = 1; slow_decay = 1;
    step(40);
    slow_decay = 0; step(40);
    // R12: zero lengths
    off_cycles = 0; blank_cycles = 0; step(40);
    // R9: polarity flip mid-cycle
    phase_cmd = 2'b10; step(15);
    phase_cmd = 2'b01; step(5);
    // R10: enable drop while active, then off command
    enable = 0; step(3); enable = 1; step(20);
    phase_cmd = 2'b11; step(3); phase_cmd = 2'b10; step(20);
    trip = 0; off_cycles = 7; blank_cycles = 2;
    // random phase
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      cyc++;
      check_now();
      trip = ($urandom % 6) == 0;
      if (($urandom % 300) == 0) phase_cmd = 2'($urandom);
      else if (phase_cmd == 2'b00 || phase_cmd == 2'b11)
        if (($urandom % 10) == 0) phase_cmd = ($urandom % 2) ? 2'b01 : 2'b10;
      if (($urandom % 500) == 0) enable = 0;
      else if (!enable && ($urandom % 4) == 0) enable = 1;
      if (($urandom % 40) == 0) slow_decay = ~slow_decay;
      if (($urandom % 200) == 0) off_cycles = 12'($urandom % 30);
      if (($urandom % 200) == 0) blank_cycles = 8'($urandom % 8);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_200_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule